// File: doc/BRIEF.md
# RDS Block Data-Available Notifier

This block sits between an RDS/RBDS block decoder and the host-facing register file. It watches per-block events from the decoder and decides when to tell the host that fresh block data is waiting. It signals this on an active-low data-available line, and it drives a write enable for the output registers.

The notification rules depend on the synchronization state. During synchronization search, the host is told when the decoder reports lock, which happens after two blocks arrive in the correct order. In the fast-PI mode it is also told about each valid A-block. While locked, the cadence is one notification per block or one per pair of blocks, chosen by the mode. Loss of lock and a supply-reset condition always notify.

If the host is too slow, a new locked block sets an overflow flag. The output registers then stay frozen until the host completes a read. A host-issued restart command is passed to the decoder as a single-cycle restart request.

Top module: `rds_dav_ctrl`

## Requirements
- R1: After a synchronous reset, `dav_n` is 0 (the reset condition is reported), `ovf` is 0 and `restart_sync` is 0.
- R2: In modes 2'b00 and 2'b11 (each block) and in mode 2'b01 (fast PI), a block received while `synced` is high raises `upd_en` in that cycle and drives `dav_n` low on the next cycle.
- R3: In mode 2'b10 (pair), only every second block received while `synced` is high notifies. The pair count is cleared by `ev_sync_found`, `ev_sync_lost`, `ev_reset` and `restart_cmd`, so the first notification after any of these follows two fresh blocks.
- R4: While `synced` is low, a block with `ev_blk_a` and `ev_blk_ok` both high notifies only in mode 2'b01. Such a block notifies in no other mode, and an A-block that is not valid never notifies.
- R5: `ev_sync_found` notifies in every mode.
- R6: `ev_sync_lost` and `ev_reset` notify in every mode. `ev_reset` also clears `ovf` and the unread state.
- R7: `host_rd_start` returns `dav_n` high on the next cycle, unless a notification with update happens in the same cycle. A notification wins.
- R8: A block received while `synced` is high sets `ovf` on the next cycle if an update has been issued since the last `host_rd_done` and no `host_rd_done` arrives in that cycle.
- R9: While `ovf` is high, `upd_en` stays low and `dav_n` is not driven low (except by `ev_reset`). `host_rd_done` clears `ovf` on the next cycle.
- R10: `restart_sync` is high in the cycle after `restart_cmd` is high, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Notification mode: 00 each block, 01 fast PI, 10 pair, 11 each block |
| synced | input | 1 | Decoder is locked |
| ev_block | input | 1 | One-cycle pulse: a block was received |
| ev_blk_a | input | 1 | The received block is an A-block |
| ev_blk_ok | input | 1 | The received block is valid |
| ev_sync_found | input | 1 | Pulse: two blocks were found in sequence and lock was gained |
| ev_sync_lost | input | 1 | Pulse: the flywheel overflowed and lock was lost |
| ev_reset | input | 1 | Pulse: a power-on or voltage-drop condition was seen |
| restart_cmd | input | 1 | Host command to restart the synchronization search |
| host_rd_start | input | 1 | Pulse: the host began reading |
| host_rd_done | input | 1 | Pulse: the host finished reading |
| dav_n | output | 1 | Data available, active low |
| ovf | output | 1 | Overflow flag |
| upd_en | output | 1 | Output register update enable |
| restart_sync | output | 1 | Restart request to the decoder |

## Verification
A wrong pair count shows up as a `dav_n` edge on the wrong locked block. The error appears one cycle after that block and persists until the next clearing event. A stale unread state shows up at the ports in one of two ways: `ovf` rises when it should not, or it fails to rise on the next locked block. Once `ovf` is wrong, `upd_en` is suppressed and the fault stays visible until a read completes. Comparing against a model on every cycle catches these faults on the first cycle in which they differ.

// File: rtl/rds_dav_pkg.sv
package rds_dav_pkg;
  typedef enum logic [1:0] {
    DAV_EACH  = 2'b00,
    DAV_PI    = 2'b01,
    DAV_PAIR  = 2'b10,
    DAV_EACH2 = 2'b11
  } dav_mode_e;

  // advance a modulo block counter
  function automatic int unsigned cnt_next(input int unsigned cur, input int unsigned lim);
    return (cur + 1 >= lim) ? 0 : cur + 1;
  endfunction

  // true when the current block completes a group
  function automatic logic cnt_last(input int unsigned cur, input int unsigned lim);
    return (cur + 1 >= lim);
  endfunction
endpackage

// File: rtl/rds_dav_qual.sv
module rds_dav_qual
  import rds_dav_pkg::*;
#(
  parameter int unsigned BLK_PER_NOTE = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  dav_mode_e  mode,
  input  logic       synced,
  input  logic       ev_block,
  input  logic       ev_blk_a,
  input  logic       ev_blk_ok,
  input  logic       ev_sync_found,
  input  logic       ev_sync_lost,
  input  logic       ev_reset,
  input  logic       restart_cmd,
  output logic       notify,
  output logic       locked_blk
);
  localparam int unsigned CW = (BLK_PER_NOTE > 1) ? $clog2(BLK_PER_NOTE) : 1;

  logic [CW-1:0] cnt_q;
  logic          cnt_clr;
  logic          pair_mode;
  logic          pair_hit;
  logic          note_locked;
  logic          note_pi;

  assign cnt_clr     = ev_reset | ev_sync_lost | ev_sync_found | restart_cmd;
  assign locked_blk  = synced & ev_block;
  assign pair_mode   = (mode == DAV_PAIR);
  assign pair_hit    = locked_blk & pair_mode & cnt_last(int'(cnt_q), BLK_PER_NOTE);
  assign note_locked = locked_blk & (pair_mode ? pair_hit : 1'b1);
  assign note_pi     = ~synced & ev_block & ev_blk_a & ev_blk_ok & (mode == DAV_PI);
  assign notify      = ev_reset | ev_sync_lost | ev_sync_found | note_locked | note_pi;

  always_ff @(posedge clk) begin
    if (rst || cnt_clr) begin
      cnt_q <= '0;
    end else if (locked_blk && pair_mode) begin
      cnt_q <= CW'(cnt_next(int'(cnt_q), BLK_PER_NOTE));
    end
  end

  // R3
  pair_clear_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_clr |=> !pair_hit);

  // R4
  pi_unsynced_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_block && !synced && mode != DAV_PI && !cnt_clr) |-> !notify);
endmodule

// File: rtl/rds_dav_hs.sv
module rds_dav_hs (
  input  logic clk,
  input  logic rst,
  input  logic ev_reset,
  input  logic notify,
  input  logic locked_blk,
  input  logic host_rd_start,
  input  logic host_rd_done,
  output logic dav_n,
  output logic ovf,
  output logic upd_en
);
  logic unread_q;
  logic ovf_q;
  logic dav_q;
  logic ovf_set;

  assign ovf_set = locked_blk & unread_q & ~host_rd_done & ~ev_reset;
  assign upd_en  = ev_reset | (notify & ~ovf_q & ~ovf_set);
  assign dav_n   = dav_q;
  assign ovf     = ovf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dav_q <= 1'b0;
    end else if (upd_en) begin
      dav_q <= 1'b0;
    end else if (host_rd_start) begin
      dav_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || ev_reset) begin
      unread_q <= 1'b0;
    end else if (upd_en) begin
      unread_q <= 1'b1;
    end else if (host_rd_done) begin
      unread_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || ev_reset) begin
      ovf_q <= 1'b0;
    end else if (ovf_set) begin
      ovf_q <= 1'b1;
    end else if (host_rd_done) begin
      ovf_q <= 1'b0;
    end
  end

  // R8
  ovf_rise_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_set |=> ovf_q);

  // R9
  frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && !ev_reset) |-> !upd_en);

  // R9
  ovf_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && host_rd_done && !ovf_set) |=> !ovf_q);
endmodule

// File: rtl/rds_dav_restart.sv
module rds_dav_restart (
  input  logic clk,
  input  logic rst,
  input  logic restart_cmd,
  output logic restart_sync
);
  logic req_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
    end else begin
      req_q <= restart_cmd;
    end
  end

  assign restart_sync = req_q;

  // R10
  restart_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    restart_cmd |=> restart_sync);

  // R10
  restart_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !restart_cmd |=> !restart_sync);
endmodule

// File: rtl/rds_dav_ctrl.sv
module rds_dav_ctrl
  import rds_dav_pkg::*;
#(
  parameter int unsigned BLK_PER_NOTE = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode,
  input  logic       synced,
  input  logic       ev_block,
  input  logic       ev_blk_a,
  input  logic       ev_blk_ok,
  input  logic       ev_sync_found,
  input  logic       ev_sync_lost,
  input  logic       ev_reset,
  input  logic       restart_cmd,
  input  logic       host_rd_start,
  input  logic       host_rd_done,
  output logic       dav_n,
  output logic       ovf,
  output logic       upd_en,
  output logic       restart_sync
);
  logic notify;
  logic locked_blk;

  rds_dav_qual #(.BLK_PER_NOTE(BLK_PER_NOTE)) u_qual (
    .clk          (clk),
    .rst          (rst),
    .mode         (dav_mode_e'(mode)),
    .synced       (synced),
    .ev_block     (ev_block),
    .ev_blk_a     (ev_blk_a),
    .ev_blk_ok    (ev_blk_ok),
    .ev_sync_found(ev_sync_found),
    .ev_sync_lost (ev_sync_lost),
    .ev_reset     (ev_reset),
    .restart_cmd  (restart_cmd),
    .notify       (notify),
    .locked_blk   (locked_blk)
  );

  rds_dav_hs u_hs (
    .clk          (clk),
    .rst          (rst),
    .ev_reset     (ev_reset),
    .notify       (notify),
    .locked_blk   (locked_blk),
    .host_rd_start(host_rd_start),
    .host_rd_done (host_rd_done),
    .dav_n        (dav_n),
    .ovf          (ovf),
    .upd_en       (upd_en)
  );

  rds_dav_restart u_restart (
    .clk         (clk),
    .rst         (rst),
    .restart_cmd (restart_cmd),
    .restart_sync(restart_sync)
  );

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!dav_n && !ovf && !restart_sync));

  // R2
  dav_low_chk: assert property (@(posedge clk) disable iff (rst)
    upd_en |=> !dav_n);

  // R7
  dav_release_chk: assert property (@(posedge clk) disable iff (rst)
    (host_rd_start && !upd_en) |=> dav_n);

  // R6
  any_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_sync_lost && !ovf) |-> upd_en);
endmodule

// File: tb/rds_dav_ctrl_bench.sv
module rds_dav_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode = 2'b00;
  logic       synced = 1'b0;
  logic       ev_block = 1'b0, ev_blk_a = 1'b0, ev_blk_ok = 1'b0;
  logic       ev_sync_found = 1'b0, ev_sync_lost = 1'b0, ev_reset = 1'b0;
  logic       restart_cmd = 1'b0, host_rd_start = 1'b0, host_rd_done = 1'b0;
  logic       dav_n, ovf, upd_en, restart_sync;

  int checks = 0;
  int failures = 0;
  bit live = 1'b0;

  always #2 clk = ~clk;

  rds_dav_ctrl u_rds_dav_ctrl (
    .clk(clk), .rst(rst), .mode(mode), .synced(synced),
    .ev_block(ev_block), .ev_blk_a(ev_blk_a), .ev_blk_ok(ev_blk_ok),
    .ev_sync_found(ev_sync_found), .ev_sync_lost(ev_sync_lost), .ev_reset(ev_reset),
    .restart_cmd(restart_cmd), .host_rd_start(host_rd_start), .host_rd_done(host_rd_done),
    .dav_n(dav_n), .ovf(ovf), .upd_en(upd_en), .restart_sync(restart_sync)
  );

  // behavioural reference
  int m_dav = 0, m_ovf = 0, m_unread = 0, m_blocks = 0, m_rs = 0;

  function automatic int m_notice();
    int n = 0;
    if (ev_reset || ev_sync_lost || ev_sync_found) n = 1;
    if (ev_block && synced) begin
      if (mode == 2'b10) begin
        if (m_blocks % 2 == 1) n = 1;
      end else begin
        n = 1;
      end
    end
    if (ev_block && !synced && mode == 2'b01 && ev_blk_a && ev_blk_ok) n = 1;
    return n;
  endfunction

  function automatic int m_overrun();
    return (ev_block && synced && m_unread == 1 && !host_rd_done && !ev_reset) ? 1 : 0;
  endfunction

  function automatic int m_upd();
    if (ev_reset) return 1;
    if (m_ovf == 1 || m_overrun() == 1) return 0;
    return m_notice();
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_dav = 0; m_ovf = 0; m_unread = 0; m_blocks = 0; m_rs = 0;
    end else begin
      int u, o;
      u = m_upd();
      o = m_overrun();
      if (u == 1) m_dav = 0;
      else if (host_rd_start) m_dav = 1;
      if (ev_reset) m_unread = 0;
      else if (u == 1) m_unread = 1;
      else if (host_rd_done) m_unread = 0;
      if (ev_reset) m_ovf = 0;
      else if (o == 1) m_ovf = 1;
      else if (host_rd_done) m_ovf = 0;
      if (ev_reset || ev_sync_lost || ev_sync_found || restart_cmd) m_blocks = 0;
      else if (ev_block && synced && mode == 2'b10) m_blocks = m_blocks + 1;
      m_rs = restart_cmd ? 1 : 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // compare on every clock, mid-cycle
  always @(negedge clk) begin
    if (live && !rst) begin
      chk(int'(dav_n) == m_dav, "R7 dav_n model", int'(dav_n), m_dav);
      chk(int'(ovf) == m_ovf, "R8 ovf model", int'(ovf), m_ovf);
      chk(int'(upd_en) == m_upd(), "R9 upd_en model", int'(upd_en), m_upd());
      chk(int'(restart_sync) == m_rs, "R10 restart model", int'(restart_sync), m_rs);
    end
  end

  // apply a set of pulses for one cycle; outputs are settled on return
  task automatic cyc(input bit blk, input bit a, input bit ok, input bit fnd, input bit lst,
                     input bit rse, input bit rsc, input bit rds, input bit rdd);
    ev_block = blk; ev_blk_a = a; ev_blk_ok = ok; ev_sync_found = fnd;
    ev_sync_lost = lst; ev_reset = rse; restart_cmd = rsc;
    host_rd_start = rds; host_rd_done = rdd;
    @(posedge clk); #1;
    ev_block = 0; ev_blk_a = 0; ev_blk_ok = 0; ev_sync_found = 0;
    ev_sync_lost = 0; ev_reset = 0; restart_cmd = 0;
    host_rd_start = 0; host_rd_done = 0;
  endtask

  task automatic blk();      cyc(1,0,1,0,0,0,0,0,0); endtask
  task automatic rd_start(); cyc(0,0,0,0,0,0,0,1,0); endtask
  task automatic rd_done();  cyc(0,0,0,0,0,0,0,0,1); endtask
  task automatic rd_all();   rd_start(); rd_done(); endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    live = 1'b1;
    chk(dav_n == 1'b0 && ovf == 1'b0 && restart_sync == 1'b0, "R1 reset state",
        int'({dav_n, ovf, restart_sync}), 0);
    rd_start();
    chk(dav_n == 1'b1, "R7 release", int'(dav_n), 1);

    // sync search, non-PI mode: A-block ignored
    mode = 2'b00; synced = 0;
    cyc(1,1,1,0,0,0,0,0,0);
    chk(dav_n == 1'b1, "R4 A-block in mode 00", int'(dav_n), 1);
    mode = 2'b01;
    cyc(1,1,1,0,0,0,0,0,0);
    chk(dav_n == 1'b0, "R4 A-block in PI mode", int'(dav_n), 0);
    rd_all();
    cyc(1,1,0,0,0,0,0,0,0);
    chk(dav_n == 1'b1, "R4 invalid A-block", int'(dav_n), 1);
    mode = 2'b10;
    cyc(0,0,0,1,0,0,0,0,0);
    chk(dav_n == 1'b0, "R5 sync found", int'(dav_n), 0);
    rd_all();

    // locked, single-block modes
    synced = 1; mode = 2'b00;
    blk();
    chk(dav_n == 1'b0, "R2 mode 00 block", int'(dav_n), 0);
    rd_all();
    mode = 2'b11;
    blk();
    chk(dav_n == 1'b0, "R2 mode 11 block", int'(dav_n), 0);
    rd_all();

    // pair mode
    mode = 2'b10;
    blk();
    chk(dav_n == 1'b1, "R3 first of pair", int'(dav_n), 1);
    rd_done();
    blk();
    chk(dav_n == 1'b0, "R3 second of pair", int'(dav_n), 0);
    rd_all();
    blk();
    cyc(0,0,0,0,1,0,0,0,0);
    chk(dav_n == 1'b0, "R6 sync lost", int'(dav_n), 0);
    rd_all();
    blk();
    chk(dav_n == 1'b1, "R3 cleared by loss", int'(dav_n), 1);
    blk();
    chk(dav_n == 1'b0, "R3 pair after loss", int'(dav_n), 0);
    rd_all();
    blk();
    cyc(0,0,0,0,0,0,1,0,0);
    chk(restart_sync == 1'b1, "R10 restart pulse", int'(restart_sync), 1);
    rd_done();
    chk(restart_sync == 1'b0, "R10 restart ends", int'(restart_sync), 0);
    blk();
    chk(dav_n == 1'b1, "R3 cleared by restart", int'(dav_n), 1);
    blk();
    chk(dav_n == 1'b0, "R3 pair after restart", int'(dav_n), 0);
    rd_all();

    // overflow and freeze
    mode = 2'b00;
    blk();
    blk();
    chk(ovf == 1'b1, "R8 overflow set", int'(ovf), 1);
    rd_start();
    chk(dav_n == 1'b1, "R7 release while ovf", int'(dav_n), 1);
    blk();
    chk(dav_n == 1'b1, "R9 frozen dav", int'(dav_n), 1);
    rd_done();
    chk(ovf == 1'b0, "R9 overflow cleared", int'(ovf), 0);
    blk();
    chk(dav_n == 1'b0, "R9 resumes", int'(dav_n), 0);
    blk();
    chk(ovf == 1'b1, "R8 overflow again", int'(ovf), 1);
    cyc(0,0,0,0,0,1,0,1,0);
    chk(ovf == 1'b0 && dav_n == 1'b0, "R6 reset event", int'({ovf, dav_n}), 0);
    rd_start();
    blk();
    chk(ovf == 1'b0 && dav_n == 1'b0, "R6 unread cleared by reset event",
        int'({ovf, dav_n}), 0);
    rd_all();

    // read completes in same cycle as block: no overflow
    blk();
    cyc(1,0,1,0,0,0,0,0,1);
    chk(ovf == 1'b0, "R8 read done same cycle", int'(ovf), 0);
    repeat (4) @(posedge clk);
    #1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule